// File: doc/BRIEF.md
# Banked Register Store with Timed Commit

This block holds sixteen 8-bit setting registers, grouped as four banks of four, for a digitally controlled potentiometer. It sits behind the serial command decoder. The decoder hands it write requests, which are either a host byte write or a copy of the current wiper position into a register. The block does not write a request at once. It keeps the request pending until the chip-select line goes back high, and only a request whose whole frame arrived is committed. Each commit starts an internal write cycle, and a busy flag stays high for a fixed, parameterised number of clock cycles while the cycle runs.

A low level on the write-protect pin stops a commit from happening. A request that arrives while the busy flag is high is dropped. Only bank 0 may take the wiper position. Any register can be read at any time through a registered read port, and this includes reads during a write cycle.

The register contents are kept through the logic reset, which stands in for a power cycle. A recall strobe returns bank 0 register 0 so the wiper block can load its power-up position.

Top module: `nvbank_regfile`

## Requirements
- R1: A register is selected by the 2-bit bank on `rd_bank` and the 2-bit register number on `rd_reg`, which together give 16 distinct 8-bit locations. `rd_data` shows the selected location one clock after the address is sampled.
- R2: A host write is requested with `req_kind` = 0, and its byte arrives with `data_valid`. The byte reaches storage on the first clock edge at which `sel_n` is sampled high after having been low. A read made before that edge still returns the old value.
- R3: A wiper transfer is requested with `req_kind` = 1. It captures `wiper_val` at the time of the request and commits that value on the closing edge. If it is aimed at bank 1, 2 or 3 it is discarded: no busy period starts and the register is left unchanged.
- R4: `busy` goes high on the clock after a commit and stays high for exactly `BUSY_CYCLES` clocks. It is low at all other times.
- R5: When `wp_n` is low on the closing edge, nothing is committed: storage is unchanged and `busy` stays low.
- R6: A request that arrives while `busy` is high is discarded. Reads during `busy` return the stored values.
- R7: If `sel_n` rises before the data byte of a host write has arrived, the pending write is cancelled. Nothing is committed and `busy` stays low.
- R8: Reset clears `busy`, `rd_data` and `recall_valid` and ends a running write cycle, but leaves the register contents intact.
- R9: One clock after `recall_req`, `recall_valid` pulses for one clock and `recall_data` holds bank 0 register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; storage is kept |
| sel_n | input | 1 | Chip select, active low; its rising edge closes a frame |
| req_valid | input | 1 | Write request strobe from the command decoder |
| req_kind | input | 1 | 0 = host byte write, 1 = wiper-to-register transfer |
| req_bank | input | 2 | Target bank |
| req_reg | input | 2 | Target register within the bank |
| data_valid | input | 1 | Host data byte complete |
| data_in | input | 8 | Host data byte |
| wiper_val | input | 8 | Current wiper position |
| wp_n | input | 1 | Write protect, active low |
| rd_bank | input | 2 | Read bank |
| rd_reg | input | 2 | Read register |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Write cycle in progress |
| recall_req | input | 1 | Power-up recall strobe |
| recall_data | output | 8 | Bank 0 register 0 on recall |
| recall_valid | output | 1 | Recall data valid pulse |

## Verification
The bench drives every input on the falling clock edge. A commit therefore lands on the rising edge after `sel_n` is raised, and the bench samples `busy` at the next falling edge, then counts falling edges until `busy` drops so that the count must equal `BUSY_CYCLES` exactly. Reads and recall results are due one clock after their request, so the bench sets the address on one falling edge and samples on the next. Stored values are compared only after the write cycle has ended, except where R6 calls for a read during `busy`.

// File: rtl/nvbank_pkg.sv
package nvbank_pkg;

    localparam int BANK_W        = 2;
    localparam int REG_W         = 2;
    localparam int DATA_W        = 8;
    localparam int ADDR_W        = BANK_W + REG_W;
    localparam int NUM_BANKS     = 1 << BANK_W;
    localparam int REGS_PER_BANK = 1 << REG_W;

    typedef enum logic {
        REQ_HOST_WR    = 1'b0,
        REQ_WIPER_XFER = 1'b1
    } req_kind_e;

    typedef struct packed {
        logic              valid;
        logic              complete;
        req_kind_e         kind;
        logic [BANK_W-1:0] bank;
        logic [REG_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } pend_t;

    function automatic logic [ADDR_W-1:0] flat_addr(input logic [BANK_W-1:0] bank,
                                                    input logic [REG_W-1:0]  idx);
        return {bank, idx};
    endfunction

endpackage

// File: rtl/nvbank_frame_tracker.sv
module nvbank_frame_tracker
    import nvbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              req_valid,
    input  logic              req_kind,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [REG_W-1:0]  req_reg,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] wiper_val,
    input  logic              busy,
    output pend_t             pend,
    output logic              frame_end
);

    logic      sel_q;
    req_kind_e kind_in;

    assign kind_in   = req_kind_e'(req_kind);
    assign frame_end = sel_n & ~sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b1;
            pend  <= '0;
        end else begin
            sel_q <= sel_n;
            if (frame_end) begin
                pend <= '0;
            end else if (req_valid && !sel_n && !busy) begin
                // transfers into banks other than 0 are refused at capture
                pend.valid    <= (kind_in == REQ_HOST_WR) || (req_bank == '0);
                pend.complete <= (kind_in == REQ_WIPER_XFER);
                pend.kind     <= kind_in;
                pend.bank     <= req_bank;
                pend.idx      <= req_reg;
                pend.data     <= wiper_val;
            end else if (data_valid && !sel_n && pend.valid && !pend.complete
                         && pend.kind == REQ_HOST_WR) begin
                pend.data     <= data_in;
                pend.complete <= 1'b1;
            end
        end
    end

    // R7: closing a frame always drops whatever was pending
    p_frame_clears_r7: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !pend.valid);

    // R6: a request seen while busy leaves nothing pending
    p_busy_discard_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid && !sel_n && !pend.valid) |=> !pend.valid);

endmodule

// File: rtl/nvbank_write_timer.sv
module nvbank_write_timer #(
    parameter int BUSY_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CNT_W'(BUSY_CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    // R4: a commit always raises the flag on the next clock
    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R4: with no commit, an idle timer stays idle
    p_idle_stays_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

endmodule

// File: rtl/nvbank_store.sv
module nvbank_store
    import nvbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [REG_W-1:0]  rd_reg,
    output logic [DATA_W-1:0] rd_data,
    input  logic              recall_req,
    output logic [DATA_W-1:0] recall_data,
    output logic              recall_valid
);

    localparam int BANK_BITS = REGS_PER_BANK * DATA_W;

    logic [BANK_BITS-1:0] bank_flat [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_BITS-1:0] cells;

        // no reset: contents model nonvolatile cells
        always_ff @(posedge clk) begin
            for (int r = 0; r < REGS_PER_BANK; r++) begin
                if (wr_en && wr_addr == ADDR_W'(b * REGS_PER_BANK + r))
                    cells[r*DATA_W +: DATA_W] <= wr_data;
            end
        end

        assign bank_flat[b] = cells;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data      <= '0;
            recall_data  <= '0;
            recall_valid <= 1'b0;
        end else begin
            rd_data      <= bank_flat[rd_bank][rd_reg*DATA_W +: DATA_W];
            recall_valid <= recall_req;
            if (recall_req)
                recall_data <= bank_flat[0][DATA_W-1:0];
        end
    end

    // R9: recall answers on the following clock
    p_recall_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        recall_req |=> recall_valid);

endmodule

// File: rtl/nvbank_regfile.sv
module nvbank_regfile
    import nvbank_pkg::*;
#(
    parameter int BUSY_CYCLES = 2_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              req_valid,
    input  logic              req_kind,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [REG_W-1:0]  req_reg,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] wiper_val,
    input  logic              wp_n,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [REG_W-1:0]  rd_reg,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    input  logic              recall_req,
    output logic [DATA_W-1:0] recall_data,
    output logic              recall_valid
);

    pend_t pend;
    logic  frame_end;
    logic  commit;

    nvbank_frame_tracker u_track (
        .clk        (clk),
        .rst        (rst),
        .sel_n      (sel_n),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_bank   (req_bank),
        .req_reg    (req_reg),
        .data_valid (data_valid),
        .data_in    (data_in),
        .wiper_val  (wiper_val),
        .busy       (busy),
        .pend       (pend),
        .frame_end  (frame_end)
    );

    assign commit = frame_end & pend.valid & pend.complete & wp_n & ~busy;

    nvbank_write_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (commit),
        .busy  (busy)
    );

    nvbank_store u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (commit),
        .wr_addr      (flat_addr(pend.bank, pend.idx)),
        .wr_data      (pend.data),
        .rd_bank      (rd_bank),
        .rd_reg       (rd_reg),
        .rd_data      (rd_data),
        .recall_req   (recall_req),
        .recall_data  (recall_data),
        .recall_valid (recall_valid)
    );

    // R5: a protected close never starts a write cycle
    p_wp_block_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !wp_n && !busy) |=> !busy);

    // R7: a frame closed with its data missing starts no write cycle
    p_short_frame_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_end && pend.valid && !pend.complete && !busy) |=> !busy);

endmodule

// File: tb/nvbank_regfile_tb_top.sv
module nvbank_regfile_tb_top;

    localparam int BUSY = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_kind = 1'b0;
    logic [1:0] req_bank = '0;
    logic [1:0] req_reg = '0;
    logic       data_valid = 1'b0;
    logic [7:0] data_in = '0;
    logic [7:0] wiper_val = '0;
    logic       wp_n = 1'b1;
    logic [1:0] rd_bank = '0;
    logic [1:0] rd_reg = '0;
    logic [7:0] rd_data;
    logic       busy;
    logic       recall_req = 1'b0;
    logic [7:0] recall_data;
    logic       recall_valid;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    logic [7:0] model [16];

    always #2.5 clk = ~clk;

    nvbank_regfile #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .req_valid(req_valid),
        .req_kind(req_kind), .req_bank(req_bank), .req_reg(req_reg),
        .data_valid(data_valid), .data_in(data_in), .wiper_val(wiper_val),
        .wp_n(wp_n), .rd_bank(rd_bank), .rd_reg(rd_reg), .rd_data(rd_data),
        .busy(busy), .recall_req(recall_req), .recall_data(recall_data),
        .recall_valid(recall_valid)
    );

    // {wp_n, bank, reg, data}
    localparam logic [12:0] VEC [6] = '{
        {1'b1, 2'd0, 2'd0, 8'h3C},
        {1'b1, 2'd1, 2'd3, 8'h81},
        {1'b1, 2'd3, 2'd2, 8'hFF},
        {1'b0, 2'd1, 2'd3, 8'h55},
        {1'b1, 2'd2, 2'd1, 8'h00},
        {1'b1, 2'd0, 2'd2, 8'h7E}
    };

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual !== expected) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
        end
    endtask

    task automatic frame_write(input logic [1:0] b, input logic [1:0] r,
                               input logic [7:0] d, input bit give_data);
        @(negedge clk) sel_n = 1'b0;
        @(negedge clk) begin req_valid = 1'b1; req_kind = 1'b0; req_bank = b; req_reg = r; end
        @(negedge clk) begin
            req_valid = 1'b0;
            if (give_data) begin data_valid = 1'b1; data_in = d; end
        end
        @(negedge clk) data_valid = 1'b0;
        @(negedge clk) sel_n = 1'b1;
    endtask

    task automatic frame_xfer(input logic [1:0] b, input logic [1:0] r);
        @(negedge clk) sel_n = 1'b0;
        @(negedge clk) begin req_valid = 1'b1; req_kind = 1'b1; req_bank = b; req_reg = r; end
        @(negedge clk) req_valid = 1'b0;
        @(negedge clk) sel_n = 1'b1;
    endtask

    task automatic read_reg(input logic [1:0] b, input logic [1:0] r, output logic [7:0] d);
        @(negedge clk) begin rd_bank = b; rd_reg = r; end
        @(negedge clk) d = rd_data;
    endtask

    // samples busy after the closing edge, then counts its length
    task automatic busy_len(output int len);
        len = 0;
        @(negedge clk);
        while (busy) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: all requirements, actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int len;

        // R8: reset values
        repeat (3) @(negedge clk);
        check("R8 reset busy", busy, 0);
        check("R8 reset rd_data", rd_data, 0);
        check("R8 reset recall_valid", recall_valid, 0);
        @(negedge clk) rst = 1'b0;

        // R1 R2 R4 R5: vector walk
        for (int i = 0; i < 6; i++) begin
            logic       v_wp;
            logic [1:0] v_b, v_r;
            logic [7:0] v_d;
            {v_wp, v_b, v_r, v_d} = VEC[i];
            wp_n = v_wp;
            frame_write(v_b, v_r, v_d, 1'b1);
            busy_len(len);
            if (v_wp) begin
                model[{v_b, v_r}] = v_d;
                check("R4 busy length", len, BUSY);
            end else begin
                check("R5 protected close keeps busy low", len, 0);
            end
            wp_n = 1'b1;
            read_reg(v_b, v_r, got);
            check("R1 R2 readback", got, model[{v_b, v_r}]);
        end

        // R2: value not visible before the closing edge
        @(negedge clk) sel_n = 1'b0;
        @(negedge clk) begin req_valid = 1'b1; req_kind = 1'b0; req_bank = 2'd2; req_reg = 2'd1; end
        @(negedge clk) begin req_valid = 1'b0; data_valid = 1'b1; data_in = 8'hC3; end
        @(negedge clk) begin data_valid = 1'b0; rd_bank = 2'd2; rd_reg = 2'd1; end
        @(negedge clk) check("R2 no early write", rd_data, model[{2'd2, 2'd1}]);
        sel_n = 1'b1;
        model[{2'd2, 2'd1}] = 8'hC3;
        busy_len(len);
        read_reg(2'd2, 2'd1, got);
        check("R2 write after close", got, 8'hC3);

        // R3: wiper transfer into bank 0
        wiper_val = 8'hA5;
        frame_xfer(2'd0, 2'd3);
        wiper_val = 8'h11;
        busy_len(len);
        check("R3 transfer busy", len, BUSY);
        read_reg(2'd0, 2'd3, got);
        check("R3 transfer value", got, 8'hA5);
        model[{2'd0, 2'd3}] = 8'hA5;

        // R3: transfer aimed at bank 1 is discarded
        wiper_val = 8'h5A;
        frame_xfer(2'd1, 2'd3);
        busy_len(len);
        check("R3 bank1 transfer no busy", len, 0);
        read_reg(2'd1, 2'd3, got);
        check("R3 bank1 unchanged", got, model[{2'd1, 2'd3}]);

        // R6: requests during busy dropped, reads served
        frame_write(2'd3, 2'd0, 8'h99, 1'b1);
        model[{2'd3, 2'd0}] = 8'h99;
        read_reg(2'd1, 2'd3, got);
        check("R6 busy during read", busy, 1);
        check("R6 read during busy", got, model[{2'd1, 2'd3}]);
        frame_write(2'd0, 2'd2, 8'hEE, 1'b1);
        while (busy) @(negedge clk);
        read_reg(2'd0, 2'd2, got);
        check("R6 write during busy dropped", got, model[{2'd0, 2'd2}]);
        read_reg(2'd3, 2'd0, got);
        check("R6 first write kept", got, 8'h99);

        // R7: short frame cancelled
        frame_write(2'd3, 2'd2, 8'h12, 1'b0);
        busy_len(len);
        check("R7 short frame no busy", len, 0);
        @(negedge clk) sel_n = 1'b0;
        @(negedge clk) sel_n = 1'b1;
        busy_len(len);
        check("R7 later close no busy", len, 0);
        read_reg(2'd3, 2'd2, got);
        check("R7 short frame value", got, model[{2'd3, 2'd2}]);

        // R9: recall
        @(negedge clk) recall_req = 1'b1;
        @(negedge clk) begin
            recall_req = 1'b0;
            check("R9 recall valid", recall_valid, 1);
            check("R9 recall data", recall_data, model[0]);
        end
        @(negedge clk) check("R9 single pulse", recall_valid, 0);

        // R8: reset mid write cycle keeps contents
        frame_write(2'd1, 2'd0, 8'h6D, 1'b1);
        model[{2'd1, 2'd0}] = 8'h6D;
        @(negedge clk) check("R8 busy before reset", busy, 1);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R8 busy cleared", busy, 0);
        read_reg(2'd1, 2'd0, got);
        check("R8 contents kept", got, 8'h6D);
        read_reg(2'd0, 2'd3, got);
        check("R8 older contents kept", got, 8'hA5);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule